// File: doc/BRIEF.md
# Programmable SPI Master with Select Lines

This block is an SPI master controlled through a small word-addressed register file. A host loads up to four transmit words and programs a control word, a clock divider and an eight-line slave-select register. A control write with the go bit set starts a transfer. One control word sets the frame length (1 to 128 bits), the bit order, the edge on which the serial output changes, the edge on which the serial input is sampled, automatic select handling and a completion interrupt.

While the transfer runs, the go bit reads back as 1 and every register write is ignored. Received bits are stored into the same data words, in the positions the transmitted bits came from. When the go bit reads 0 again, the low frame bits of the data words hold the received frame. The serial clock rests low. Each half period lasts divider+1 system clocks.

Top module: `spi_xfer_master`

## Requirements
- R1: Register offsets: 0 to 3 are the data words (word 0 holds frame bits 31:0), 4 is control, 5 is the divider, 6 is the select register, and 7 reads as 0. After reset, data, control and divider read 0, the select register reads all ones, `sck` and `irq` are 0, and control reads back the fields last written, with bit 8 showing busy.
- R2: A write to offset 4 with bit 8 set starts a transfer of N bits. Bit 8 then reads 1 for exactly 2·N·(divider+1) cycles, counted from the clock edge that took the write. During that time `sck` starts low and makes N rising and N falling transitions, one every divider+1 cycles.
- R3: Control bits 6:0 give N. A value of 0 means N = 128, and any other value means N equals that value.
- R4: Control bit 11 = 0 sends frame bits N-1 down to 0 (MSB first). Bit 11 = 1 sends bits 0 up to N-1. Received bits fill the same positions in the same order.
- R5: Control bit 10 = 1 makes `mosi` change on falling `sck` transitions, with the first bit driven from the start of the transfer. Bit 10 = 0 makes `mosi` change on rising transitions, with the first bit appearing at the first rising transition.
- R6: Control bit 9 = 0 samples `miso` on rising `sck` transitions. Bit 9 = 1 samples it on falling transitions.
- R7: At the end of a transfer, data bits N-1:0 hold the received bits. Data bits at N and above keep their previous values.
- R8: With control bit 13 = 0, `ssel_n` equals the select register at all times. With bit 13 = 1, `ssel_n` equals the select register while busy and is all ones otherwise.
- R9: With control bit 12 = 1, `irq` is high for exactly one cycle: the first cycle in which bit 8 reads 0 again. With bit 12 = 0, `irq` stays low.
- R10: While busy, writes to every offset are ignored. This includes data, control, divider and select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data, combinational from `host_addr` |
| sck | output | 1 | Serial clock, rests low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssel_n | output | 8 | Active-low slave selects |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The go write is taken at clock edge T. The busy bit reads 1 from just after T, and each `sck` transition lands at T + k·(divider+1). The last transition, the busy bit falling to 0 and the `irq` rise all happen together after 2·N·(divider+1) cycles. The bench drives inputs and samples every output on the falling clock. It therefore sees each `sck` transition half a cycle after it happens, and updates its modelled slave's `miso` there, well before the next sampling edge. `mosi` is captured on the transition opposite to the one that changes it. The received words are compared once the busy bit has dropped, and `irq` is checked in that cycle and in the following one.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
   localparam int CB_GO     = 8;
   localparam int CB_RXFALL = 9;
   localparam int CB_TXFALL = 10;
   localparam int CB_LSB    = 11;
   localparam int CB_IRQEN  = 12;
   localparam int CB_AUTOSS = 13;
   localparam int CTRL_W    = 14;

   typedef struct packed {
      logic auto_ss;
      logic irq_en;
      logic lsb_first;
      logic tx_fall;
      logic rx_fall;
   } spi_mode_t;
endpackage

// File: rtl/spi_edge_gen.sv
module spi_edge_gen #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             sck,
   output logic             rise,
   output logic             fall
);
   logic [DIV_W-1:0] cnt_q;
   logic             sck_q;
   logic             tick;

   assign tick = run && (cnt_q == div);
   assign rise = tick && !sck_q;
   assign fall = tick && sck_q;
   assign sck  = sck_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt_q <= '0;
         sck_q <= 1'b0;
      end else if (tick) begin
         cnt_q <= '0;
         sck_q <= ~sck_q;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
   parameter int TOTAL = 128,
   parameter int LEN_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             active,
   input  logic             lsb_first,
   input  logic             tx_fall,
   input  logic             rx_fall,
   input  logic [LEN_W-1:0] len_f,
   input  logic             rise,
   input  logic             fall,
   input  logic             miso,
   input  logic [TOTAL-1:0] tx_bits,
   output logic             mosi,
   output logic             rx_we,
   output logic [LEN_W-1:0] rx_pos,
   output logic             rx_bit,
   output logic             done
);
   localparam int CW = LEN_W + 1;
   localparam int EW = LEN_W + 2;

   logic [CW-1:0] nbits, txc_q, rxc_q;
   logic [EW-1:0] ecnt_q;
   logic          tx_edge, rx_edge, mosi_q;

   function automatic logic [LEN_W-1:0] pos_of(input logic [CW-1:0] i,
                                                input logic lsb,
                                                input logic [CW-1:0] n);
      logic [CW-1:0] t;
      t = lsb ? i : (n - i - CW'(1));
      return LEN_W'(t);
   endfunction

   assign nbits   = (len_f == '0) ? CW'(TOTAL) : {1'b0, len_f};
   assign tx_edge = tx_fall ? fall : rise;
   assign rx_edge = rx_fall ? fall : rise;
   assign rx_we   = active && rx_edge && (rxc_q < nbits);
   assign rx_pos  = pos_of(rxc_q, lsb_first, nbits);
   assign rx_bit  = miso;
   assign done    = active && (rise || fall) && (ecnt_q == ({nbits, 1'b0} - EW'(1)));
   assign mosi    = mosi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         txc_q  <= '0;
         rxc_q  <= '0;
         ecnt_q <= '0;
         mosi_q <= 1'b0;
      end else if (start) begin
         txc_q  <= tx_fall ? CW'(1) : '0;
         mosi_q <= tx_fall ? tx_bits[pos_of('0, lsb_first, nbits)] : 1'b0;
         rxc_q  <= '0;
         ecnt_q <= '0;
      end else if (active) begin
         if (tx_edge && (txc_q < nbits)) begin
            mosi_q <= tx_bits[pos_of(txc_q, lsb_first, nbits)];
            txc_q  <= txc_q + CW'(1);
         end
         if (rx_we)
            rxc_q <= rxc_q + CW'(1);
         if (rise || fall)
            ecnt_q <= ecnt_q + EW'(1);
      end
   end
endmodule

// File: rtl/spi_ss_drive.sv
module spi_ss_drive #(
   parameter int SS_N = 8
) (
   input  logic            auto_ss,
   input  logic            busy,
   input  logic [SS_N-1:0] sel_q,
   output logic [SS_N-1:0] ssel_n
);
   for (genvar gi = 0; gi < SS_N; gi++) begin : g_line
      assign ssel_n[gi] = auto_ss ? (busy ? sel_q[gi] : 1'b1) : sel_q[gi];
   end
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
   import spi_xfer_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int NUM_WORDS = 4,
   parameter int SS_N      = 8,
   parameter int DIV_W     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [2:0]        host_addr,
   input  logic [WORD_W-1:0] host_wdata,
   output logic [WORD_W-1:0] host_rdata,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   output logic [SS_N-1:0]   ssel_n,
   output logic              irq
);
   localparam int TOTAL = WORD_W * NUM_WORDS;
   localparam int LEN_W = $clog2(TOTAL);
   localparam int AW    = 3;

   if ((1 << LEN_W) != TOTAL) begin : g_bad_total
      $error("frame storage must be a power of two bits");
   end
   if (LEN_W > CB_GO) begin : g_bad_len
      $error("length field would overlap the go bit");
   end
   if (NUM_WORDS > 4) begin : g_bad_words
      $error("at most four data words fit below the control offset");
   end
   if (WORD_W < CTRL_W || SS_N > WORD_W || DIV_W > WORD_W) begin : g_bad_width
      $error("register word too narrow");
   end

   logic [TOTAL-1:0] data_q;
   logic [LEN_W-1:0] len_q, len_now;
   spi_mode_t        mode_q, mode_new, mode_now;
   logic [DIV_W-1:0] div_q;
   logic [SS_N-1:0]  ss_q;
   logic             busy_q, irq_q;
   logic             wr_ok, start;
   logic             rise, fall, rx_we, rx_bit, done;
   logic [LEN_W-1:0] rx_pos;

   assign wr_ok    = host_we && !busy_q;
   assign start    = wr_ok && (host_addr == AW'(4)) && host_wdata[CB_GO];
   assign mode_new = '{auto_ss:   host_wdata[CB_AUTOSS],
                       irq_en:    host_wdata[CB_IRQEN],
                       lsb_first: host_wdata[CB_LSB],
                       tx_fall:   host_wdata[CB_TXFALL],
                       rx_fall:   host_wdata[CB_RXFALL]};
   assign mode_now = start ? mode_new : mode_q;
   assign len_now  = start ? host_wdata[LEN_W-1:0] : len_q;
   assign irq      = irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         len_q  <= '0;
         mode_q <= '0;
         div_q  <= '0;
         ss_q   <= '1;
         busy_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= done && mode_q.irq_en;
         if (done)
            busy_q <= 1'b0;
         if (rx_we)
            data_q[rx_pos] <= rx_bit;
         if (wr_ok) begin
            for (int w = 0; w < NUM_WORDS; w++)
               if (host_addr == AW'(w))
                  data_q[w*WORD_W +: WORD_W] <= host_wdata;
            case (host_addr)
               AW'(4): begin
                  len_q  <= host_wdata[LEN_W-1:0];
                  mode_q <= mode_new;
                  busy_q <= host_wdata[CB_GO];
               end
               AW'(5): div_q <= host_wdata[DIV_W-1:0];
               AW'(6): ss_q  <= host_wdata[SS_N-1:0];
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      host_rdata = '0;
      for (int w = 0; w < NUM_WORDS; w++)
         if (host_addr == AW'(w))
            host_rdata = data_q[w*WORD_W +: WORD_W];
      case (host_addr)
         AW'(4): begin
            host_rdata[LEN_W-1:0] = len_q;
            host_rdata[CB_GO]     = busy_q;
            host_rdata[CB_RXFALL] = mode_q.rx_fall;
            host_rdata[CB_TXFALL] = mode_q.tx_fall;
            host_rdata[CB_LSB]    = mode_q.lsb_first;
            host_rdata[CB_IRQEN]  = mode_q.irq_en;
            host_rdata[CB_AUTOSS] = mode_q.auto_ss;
         end
         AW'(5): host_rdata[DIV_W-1:0] = div_q;
         AW'(6): host_rdata[SS_N-1:0]  = ss_q;
         default: ;
      endcase
   end

   spi_edge_gen #(.DIV_W(DIV_W)) u_edges (
      .clk(clk), .rst_n(rst_n), .run(busy_q), .div(div_q),
      .sck(sck), .rise(rise), .fall(fall)
   );

   spi_bit_engine #(.TOTAL(TOTAL), .LEN_W(LEN_W)) u_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .active(busy_q),
      .lsb_first(mode_now.lsb_first), .tx_fall(mode_now.tx_fall),
      .rx_fall(mode_now.rx_fall), .len_f(len_now),
      .rise(rise), .fall(fall), .miso(miso), .tx_bits(data_q),
      .mosi(mosi), .rx_we(rx_we), .rx_pos(rx_pos), .rx_bit(rx_bit), .done(done)
   );

   spi_ss_drive #(.SS_N(SS_N)) u_ss (
      .auto_ss(mode_q.auto_ss), .busy(busy_q), .sel_q(ss_q), .ssel_n(ssel_n)
   );
endmodule

// File: rtl/spi_xfer_master_chk.sv
module spi_xfer_master_chk #(
   parameter int SS_N  = 8,
   parameter int DIV_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_we,
   input logic             sck,
   input logic             irq,
   input logic [SS_N-1:0]  ssel_n,
   input logic             busy_q,
   input logic             auto_ss,
   input logic [DIV_W-1:0] div_q,
   input logic [SS_N-1:0]  ss_q
);
   a_r2_sck_rests_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !sck);

   a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   a_r9_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (!busy_q && $past(busy_q)));

   a_r8_auto_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_ss && !busy_q) |-> (ssel_n == '1));

   a_r10_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && host_we) |=> $stable(div_q));

   a_r10_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && host_we) |=> $stable(ss_q));
endmodule

bind spi_xfer_master spi_xfer_master_chk #(.SS_N(SS_N), .DIV_W(DIV_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_we(host_we), .sck(sck), .irq(irq),
   .ssel_n(ssel_n), .busy_q(busy_q), .auto_ss(mode_q.auto_ss),
   .div_q(div_q), .ss_q(ss_q)
);

// File: tb/tb_spi_xfer_master.sv
module tb_spi_xfer_master;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [2:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        sck, mosi, irq;
   logic        miso = 1'b0;
   logic [7:0]  ssel_n;
   int          total = 0, bad = 0;
   bit          finished = 0;

   always #2 clk = ~clk;

   spi_xfer_master dut (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .sck(sck), .mosi(mosi),
      .miso(miso), .ssel_n(ssel_n), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      host_we = 1'b1; host_addr = 3'(a); host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] v);
      host_addr = 3'(a);
      #1 v = host_rdata;
   endtask

   function automatic int pos_of(input int k, input int n, input bit lsb);
      return lsb ? k : n - 1 - k;
   endfunction

   task automatic xfer(input int len, input int div, input bit rxf, input bit txf,
                       input bit lsb, input bit irqe, input bit autoss, input int chip,
                       input logic [127:0] txd, input logic [127:0] sb, input bit bw);
      int n, nxt, busy_cnt, rises, mcnt, mism, iter;
      bit prev, ss_bad, irq_bad;
      logic [31:0] v, ctrl;
      logic [7:0] ssv;
      logic [127:0] exp, got;
      n = (len == 0) ? 128 : len;
      ssv = 8'hFF ^ (8'h1 << chip);
      for (int w = 0; w < 4; w++) wr(w, txd[w*32 +: 32]);
      wr(5, 32'(div));
      wr(6, {24'h0, ssv});
      ctrl = 32'(len) | (32'(rxf) << 9) | (32'(txf) << 10) | (32'(lsb) << 11)
           | (32'(irqe) << 12) | (32'(autoss) << 13);
      if (!rxf) begin miso = sb[0]; nxt = 1; end else nxt = 0;
      wr(4, ctrl | 32'h100);
      busy_cnt = 0; rises = 0; mcnt = 0; mism = 0; iter = 0;
      prev = 1'b0; ss_bad = 0; irq_bad = 0;
      while (1) begin
         host_we = 1'b0;
         rd(4, v);
         if (sck && !prev) begin
            rises++;
            if (txf) begin
               if (mosi !== txd[pos_of(mcnt, n, lsb)]) mism++;
               mcnt++;
            end
            if (rxf && nxt < 128) begin miso = sb[nxt]; nxt++; end
         end else if (!sck && prev) begin
            if (!txf) begin
               if (mosi !== txd[pos_of(mcnt, n, lsb)]) mism++;
               mcnt++;
            end
            if (!rxf && nxt < 128) begin miso = sb[nxt]; nxt++; end
         end
         prev = sck;
         if (!v[8]) break;
         busy_cnt++;
         if (ssel_n !== ssv) ss_bad = 1;
         if (irq !== 1'b0) irq_bad = 1;
         if (bw) begin
            case (iter)
               0: begin host_we = 1'b1; host_addr = 3'd5; host_wdata = 32'hABCD; end
               1: begin host_we = 1'b1; host_addr = 3'd6; host_wdata = 32'h0; end
               2: begin host_we = 1'b1; host_addr = 3'd0; host_wdata = 32'hFFFF_FFFF; end
               3: begin host_we = 1'b1; host_addr = 3'd4; host_wdata = 32'h0; end
               default: ;
            endcase
         end
         iter++;
         if (iter > 100000) break;
         @(negedge clk);
      end
      host_we = 1'b0;
      chk(busy_cnt == 2 * n * (div + 1), "R2 busy cycles", 128'(busy_cnt),
          128'(2 * n * (div + 1)));
      chk(rises == n, "R3 sck rising count", 128'(rises), 128'(n));
      chk(mism == 0 && mcnt == n, "R4/R5 mosi bit sequence", 128'(mism), 128'(0));
      chk(!ss_bad, "R8 select while busy", 128'(ssel_n), 128'(ssv));
      chk(!irq_bad && irq === irqe, "R9 irq at end", 128'(irq), 128'(irqe));
      chk(ssel_n === (autoss ? 8'hFF : ssv), "R8 select after end", 128'(ssel_n),
          128'(autoss ? 8'hFF : ssv));
      @(negedge clk);
      chk(irq === 1'b0, "R9 irq one cycle", 128'(irq), 128'(0));
      exp = txd;
      for (int k = 0; k < n; k++) exp[pos_of(k, n, lsb)] = sb[k];
      for (int w = 0; w < 4; w++) begin rd(w, v); got[w*32 +: 32] = v; end
      chk(got === exp, "R6/R7 received data", got, exp);
      rd(4, v);
      chk(v === ctrl, "R1 control readback", 128'(v), 128'(ctrl));
      rd(5, v);
      chk(v === 32'(div), "R10 divider kept", 128'(v), 128'(div));
      rd(6, v);
      chk(v === {24'h0, ssv}, "R10 select kept", 128'(v), 128'(ssv));
      @(negedge clk);
   endtask

   initial begin
      #(4 * 190000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'h5EED_0042));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int a = 0; a < 8; a++) begin
         rd(a, v);
         chk(v === ((a == 6) ? 32'hFF : 32'h0), "R1 reset readback", 128'(v),
             128'((a == 6) ? 32'hFF : 32'h0));
      end
      chk(sck === 1'b0 && irq === 1'b0 && ssel_n === 8'hFF, "R1 reset outputs",
          128'({sck, irq, ssel_n}), 128'({2'b00, 8'hFF}));
      // 16-bit MSB-first, sample on rising, change on falling, auto select
      xfer(16, 2, 0, 1, 0, 0, 1, 3, {4{32'hA5C3_1E96}}, {4{32'h6B2D_F017}}, 0);
      // length 0 means the full 128 bits, LSB first, opposite edges
      xfer(0, 0, 1, 0, 1, 1, 0, 0, {32'h1234_5678, 32'h9ABC_DEF0, 32'h0F1E_2D3C, 32'h4B5A_6978},
           {32'hDEAD_BEEF, 32'h0BAD_F00D, 32'hCAFE_1234, 32'h5555_AAAA}, 0);
      // single bit with writes attempted while busy (R10)
      xfer(1, 2, 1, 1, 0, 1, 1, 7, {4{32'h0000_0001}}, {128{1'b0}}, 1);
      xfer(7, 3, 0, 0, 1, 0, 0, 5, {4{32'h3C3C_3C3C}}, {4{32'hFFFF_FFFF}}, 1);
      for (int t = 0; t < 12; t++) begin
         logic [127:0] d, s;
         d = {$urandom, $urandom, $urandom, $urandom};
         s = {$urandom, $urandom, $urandom, $urandom};
         xfer($urandom_range(0, 127), $urandom_range(0, 3), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(0, 7), d, s,
              1'($urandom));
      end
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule